// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupt Unit

This block is a register-mapped general-purpose I/O controller for up to 31 pins. Software reaches it over a plain 32-bit register bus. A direction register selects which pins drive out. An output latch can only be changed through two write-only strobe words: one raises the chosen bits and one lowers them. A third word returns the synchronised level of every pin.

A per-pin interrupt unit watches the synchronised levels. Each pin has its own enable, trigger-type, polarity and mask bit, and a pending bit that software can read. All pins share a single interrupt line. The hardware detects only one edge direction at a time. To wait for both edges, software reverses the pin's polarity after each detected edge.

The bus has no back-pressure. A write is taken on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational and valid in the same cycle that `bus_en` is high with `bus_we` low. Reads have no side effects.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_out` and `irq` are low, and `pin_oe` is all zero when `DIR_INVERT`=0 or all ones when `DIR_INVERT`=1.
- R2: A write at byte offset 0x0C sets to 1 each latch bit whose write bit is 1. A write at 0x10 sets to 0 each latch bit whose write bit is 1. Bits written as 0 keep their value. A read at either offset returns the latch, and `pin_out` equals the latch.
- R3: The direction register at 0x00 reads back as written. With `DIR_INVERT`=0, `pin_oe` equals the register; with `DIR_INVERT`=1, `pin_oe` is its bitwise inverse.
- R4: A read at 0x04 returns `pin_in` as it was two rising clock edges earlier, through a two-stage synchroniser. Writes to 0x04 are ignored.
- R5: Read data bits at and above `PIN_COUNT` are always zero, and those write bits are discarded. Offsets outside the nine defined words (for example 0x08) read zero and ignore writes.
- R6: With the type bit (0x18) at 0, a pin is edge-triggered. Polarity 1 (0x1C) captures a low-to-high change into pending (0x20); polarity 0 captures a high-to-low change. The opposite change is not captured.
- R7: An edge-captured pending bit stays at 1 until a 1 is written to that bit at 0x20. Writing 0 there leaves it at 1.
- R8: With the type bit at 1, the pin is level-triggered. Its pending bit reads 1 exactly while it is enabled and its synchronised level equals its polarity bit. Writing 1 at 0x20 does not clear it.
- R9: With the enable bit (0x14) at 0, a qualifying edge is not captured into pending. A later enable does not recover the missed edge.
- R10: `irq` is 1 exactly when some pin has pending, enable (0x14) and mask (0x24) all at 1. A pending bit reads 1 even while its mask bit is 0.
- R11: If the polarity of an edge pin is reversed after an edge is captured, the next edge in the opposite direction is captured, and a repeat of the first direction is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output latch |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Combined interrupt line |

## Verification
The latch and direction paths are tried with a table of writes that mix raised and lowered bits, bits above the pin count, and all-zero strobes. Each read-back tells apart a latch that merges bits from one that overwrites the whole word. The interrupt unit is tried on one pin with rising, falling and reversed-polarity edges, and with level sensing at both polarities. These cases tell apart a sticky capture from a level follower, and capture-time gating by enable from output-time gating by mask. A second instance with inverted direction is run on the same bus to tell apart the two direction encodings.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IN    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_SET   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_ITYPE = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IPOL  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_IPEND = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      level  <= '0;
      prev   <= '0;
    end else begin
      meta_q <= async_in;
      level  <= meta_q;
      prev   <= level;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] trig_lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic         ack_wr,
  input  logic [W-1:0] ack_bits,
  output logic [W-1:0] pend,
  output logic         irq
);
  logic [W-1:0] sticky_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic edge_hit;
    assign edge_hit = (level[i] != prev[i]) && (level[i] == pol[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)                          sticky_q[i] <= 1'b0;
      else if (trig_lvl[i])                sticky_q[i] <= 1'b0;
      else if (en[i] && edge_hit)          sticky_q[i] <= 1'b1;
      else if (ack_wr && ack_bits[i])      sticky_q[i] <= 1'b0;
    end

    assign pend[i] = trig_lvl[i] ? (en[i] && (level[i] == pol[i])) : sticky_q[i];
  end

  assign irq = |(pend & en & mask);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT  = 24,
  parameter bit DIR_INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq
);
  localparam int PAD = BUS_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] dir_q, out_q, en_q, type_q, pol_q, mask_q;
  logic [PIN_COUNT-1:0] lvl_w, prev_w, pend_w;
  logic [PIN_COUNT-1:0] wbits;
  logic                 wr;

  assign wr    = bus_en && bus_we;
  assign wbits = bus_wdata[PIN_COUNT-1:0];

  gpio_sync #(.W(PIN_COUNT)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .level(lvl_w), .prev(prev_w)
  );

  gpio_irq_unit #(.W(PIN_COUNT)) u_irq (
    .clk(clk), .rst_n(rst_n), .level(lvl_w), .prev(prev_w),
    .en(en_q), .trig_lvl(type_q), .pol(pol_q), .mask(mask_q),
    .ack_wr(wr && (bus_addr == OFS_IPEND)), .ack_bits(wbits),
    .pend(pend_w), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      type_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_DIR:   dir_q  <= wbits;
        OFS_SET:   out_q  <= out_q | wbits;
        OFS_CLR:   out_q  <= out_q & ~wbits;
        OFS_IEN:   en_q   <= wbits;
        OFS_ITYPE: type_q <= wbits;
        OFS_IPOL:  pol_q  <= wbits;
        OFS_IMASK: mask_q <= wbits;
        default:   ;
      endcase
    end
  end

  logic [PIN_COUNT-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        OFS_DIR:   rd_sel = dir_q;
        OFS_IN:    rd_sel = lvl_w;
        OFS_SET,
        OFS_CLR:   rd_sel = out_q;
        OFS_IEN:   rd_sel = en_q;
        OFS_ITYPE: rd_sel = type_q;
        OFS_IPOL:  rd_sel = pol_q;
        OFS_IPEND: rd_sel = pend_w;
        OFS_IMASK: rd_sel = mask_q;
        default:   rd_sel = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD{1'b0}}, rd_sel};
  assign pin_out   = out_q;

  if (DIR_INVERT) begin : g_oe_inv
    assign pin_oe = ~dir_q;
  end else begin : g_oe_dir
    assign pin_oe = dir_q;
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT  = 24,
  parameter bit DIR_INVERT = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic                 irq,
  input logic [PIN_COUNT-1:0] en_q,
  input logic [PIN_COUNT-1:0] mask_q
);
  logic wr_set, wr_clr, wr_dir;
  assign wr_set = bus_en && bus_we && (bus_addr == OFS_SET);
  assign wr_clr = bus_en && bus_we && (bus_addr == OFS_CLR);
  assign wr_dir = bus_en && bus_we && (bus_addr == OFS_DIR);

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata[PIN_COUNT-1:0])) == $past(bus_wdata[PIN_COUNT-1:0]))); // R2

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata[PIN_COUNT-1:0])) == '0)); // R2

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(pin_out)); // R2

  AST_DIR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == ($past(bus_wdata[PIN_COUNT-1:0]) ^ {PIN_COUNT{DIR_INVERT}}))); // R3

  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:PIN_COUNT] == '0); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en_q & mask_q) != '0)); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.PIN_COUNT(PIN_COUNT), .DIR_INVERT(DIR_INVERT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .en_q(en_q), .mask_q(mask_q)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int N = 24;
  localparam logic [31:0] M = 32'h00FF_FFFF;
  localparam logic [5:0] A_DIR = 6'h00, A_IN = 6'h04, A_SET = 6'h0C, A_CLR = 6'h10,
    A_EN = 6'h14, A_TYP = 6'h18, A_POL = 6'h1C, A_PND = 6'h20, A_MSK = 6'h24;

  localparam int NV = 8;
  localparam logic [5:0]  V_WA[NV] = '{A_SET, A_SET, A_CLR, A_CLR, A_DIR, A_DIR, A_IN, 6'h08};
  localparam logic [31:0] V_WD[NV] = '{32'h0000_00F0, 32'hFF00_0003, 32'h0000_0030, 32'h0,
                                       32'hFFFF_FFFF, 32'h0000_00A5, 32'h0001_2345, 32'hFFFF_FFFF};
  localparam logic [5:0]  V_RA[NV] = '{A_SET, A_CLR, A_SET, A_SET, A_DIR, A_DIR, A_IN, 6'h08};
  localparam logic [31:0] V_EX[NV] = '{32'hF0, 32'hF3, 32'hC3, 32'hC3, 32'h00FF_FFFF, 32'hA5, 32'h0, 32'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] out_a, oe_a, out_b, oe_b;
  logic irq_a, irq_b;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.PIN_COUNT(N), .DIR_INVERT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pin_in(pin_in), .pin_out(out_a),
    .pin_oe(oe_a), .irq(irq_a));

  gpio_irq_ctrl #(.PIN_COUNT(N), .DIR_INVERT(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pin_in), .pin_out(out_b),
    .pin_oe(oe_b), .irq(irq_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = rd_a;
    bus_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_DIR, v); check("R1 dir", v, 0);
    rd(A_SET, v); check("R1 latch", v, 0);
    rd(A_PND, v); check("R1 pend", v, 0);
    check("R1 pin_out", {8'h0, out_a}, 0);
    check("R1 pin_oe", {8'h0, oe_a}, 0);
    check("R1 pin_oe inverted", {8'h0, oe_b}, M);
    check("R1 irq", {31'h0, irq_a}, 0);

    // R2 R3 R4 R5 register table
    for (int i = 0; i < NV; i++) begin
      wr(V_WA[i], V_WD[i]);
      rd(V_RA[i], v);
      check($sformatf("R2/R3/R4/R5 table row %0d", i), v, V_EX[i]);
    end
    check("R2 pin_out", {8'h0, out_a}, 32'hC3);
    check("R3 pin_oe", {8'h0, oe_a}, 32'hA5);
    check("R3 pin_oe inverted", {8'h0, oe_b}, M & ~32'hA5);

    // R4 two-stage synchroniser latency
    @(negedge clk); pin_in = 24'h5A5A5A;
    @(negedge clk); rd(A_IN, v); check("R4 one edge", v, 0);
    @(negedge clk); rd(A_IN, v); check("R4 two edges", v, 32'h5A5A5A);
    pin_in = '0; settle();

    // R6 R10 rising edge on pin 2
    wr(A_EN, 4); wr(A_TYP, 0); wr(A_POL, 4); wr(A_MSK, 0);
    pin_in[2] = 1'b1; settle();
    rd(A_PND, v); check("R6 rising captured", v, 4);
    check("R10 masked no irq", {31'h0, irq_a}, 0);
    wr(A_MSK, 4);
    check("R10 irq raised", {31'h0, irq_a}, 1);
    // R7 sticky and acknowledge
    wr(A_PND, 0); rd(A_PND, v); check("R7 zero write keeps", v, 4);
    wr(A_PND, 4); rd(A_PND, v); check("R7 ack clears", v, 0);
    check("R7 irq cleared", {31'h0, irq_a}, 0);
    pin_in[2] = 1'b0; settle();
    rd(A_PND, v); check("R6 falling ignored", v, 0);

    // R11 polarity reversal
    wr(A_POL, 0);
    pin_in[2] = 1'b1; settle();
    rd(A_PND, v); check("R11 rising ignored after flip", v, 0);
    pin_in[2] = 1'b0; settle();
    rd(A_PND, v); check("R11 falling captured", v, 4);
    // R10 enable gates irq of a held pending bit
    wr(A_EN, 0);
    check("R10 disabled no irq", {31'h0, irq_a}, 0);
    rd(A_PND, v); check("R10 pend still readable", v, 4);
    wr(A_PND, 4);

    // R9 disabled capture
    pin_in[2] = 1'b1; settle(); pin_in[2] = 1'b0; settle();
    rd(A_PND, v); check("R9 no capture", v, 0);
    wr(A_EN, 4); rd(A_PND, v); check("R9 no late capture", v, 0);

    // R8 level sensing
    wr(A_TYP, 4); wr(A_POL, 4);
    rd(A_PND, v); check("R8 level low inactive", v, 0);
    pin_in[2] = 1'b1; settle();
    rd(A_PND, v); check("R8 level high active", v, 4);
    check("R8 irq level", {31'h0, irq_a}, 1);
    wr(A_PND, 4); rd(A_PND, v); check("R8 ack ignored", v, 4);
    pin_in[2] = 1'b0; settle();
    rd(A_PND, v); check("R8 follows level", v, 0);
    check("R8 irq drops", {31'h0, irq_a}, 0);
    wr(A_POL, 0);
    rd(A_PND, v); check("R8 low polarity", v, 4);

    finish_run();
  end
endmodule